// File: doc/BRIEF.md
# Bridge Power-Save and Reset Sequencer

This controller sits on the host side of a display bridge. It owns two of the bridge's active-low control lines, power-down and reset, and drives each through an open-drain output. An output only ever pulls its line low or lets it go, and the bridge's own pull-up then raises the line. The controller watches two more lines: the bridge's hot-plug-detect line and a supplies-good indication from the board. Both enter through two-flop synchronizers.

After power-on the controller holds reset low until the supplies are good. It then releases reset and waits for hot-plug-detect to rise. A sleep request pulls power-down low, and the controller reports asleep only once hot-plug-detect has fallen. A wake request runs a fixed sequence: reset goes low, power-down is released while reset is still low, and reset is released after the minimum pulse width. The controller then waits for hot-plug-detect to rise again.

Requests are held pending while the video-active input is high. If a hot-plug-detect deadline expires, the controller raises a sticky timeout flag and parks in an idle error state. A bus-quiet output tells the host's I2C master to stay off the bus while reset is low, and for a settling time after reset is released. All times are derived from the `CLK_HZ` parameter.

Top module: `pwrseq_ctrl`

## Requirements
- R1: Output `rst_pull`=1 means the reset line is pulled low, and `pd_pull`=1 means the power-down line is pulled low. A value of 0 releases the line. While `ready` is 1, both outputs are 0. `ready` and `asleep` are never 1 together.
- R2: From `rst_n` low, `rst_pull` stays 1 for as long as `supplies_ok` is 0. After `supplies_ok` rises, `rst_pull` falls within 4 clock cycles.
- R3: During a wake, `rst_pull` rises before `pd_pull` falls, and `pd_pull` falls only while `rst_pull` is 1.
- R4: In a wake, `rst_pull` stays high for at least RST_CYC = ceil(CLK_HZ·RST_PULSE_US/1e6) cycles.
- R5: After reset is released, `ready` rises within 5 cycles of `hpd_in` going high. If `hpd_in` stays low for HPD_CYC cycles, `timeout` rises and `ready` stays 0.
- R6: A sleep request sets `pd_pull`. `asleep` rises only after `hpd_in` falls, within 5 cycles of that fall. If `hpd_in` stays high for HPD_CYC cycles, `timeout` rises instead.
- R7: `bus_quiet` is 1 from reset, and whenever `rst_pull` is 1. After `rst_pull` falls, it stays 1 for exactly SETTLE_CYC more cycles.
- R8: While `video_active` is 1, no pending request changes `pd_pull` or `rst_pull`. The request is acted on once `video_active` clears.
- R9: `timeout` is sticky. It is cleared when the next request is accepted. From the error state a wake request runs the full wake sequence.
- R10: A wake request that arrives during sleep entry is queued. `asleep` is first reported, and then the wake sequence starts without a further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset of the controller |
| supplies_ok | input | 1 | All supplies in range (asynchronous) |
| hpd_in | input | 1 | Bridge hot-plug-detect line (asynchronous) |
| video_active | input | 1 | Video streaming; holds off requests |
| sleep_req | input | 1 | One-cycle request to enter power save |
| wake_req | input | 1 | One-cycle request to leave power save |
| pd_pull | output | 1 | Pull power-down line low when 1, release when 0 |
| rst_pull | output | 1 | Pull reset line low when 1, release when 0 |
| bus_quiet | output | 1 | I2C traffic must not start |
| ready | output | 1 | Bridge up, hot-plug-detect seen high |
| asleep | output | 1 | Bridge in power save, hot-plug-detect seen low |
| timeout | output | 1 | Sticky hot-plug-detect deadline miss |

## Verification
Two functions can land in the same cycle: a wake request can arrive during sleep entry, and the hot-plug-detect fall can complete that entry. The bench provokes this by pulsing `wake_req` while `hpd_in` is still high in sleep entry, and only afterwards dropping `hpd_in`. It then judges that `asleep` was seen for at least one cycle before `rst_pull` rose, with no second request. A second pairing is a pending request meeting `video_active`. It is judged at the pins: they must not move during the hold, and must move once the hold ends.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP, ST_WAIT_UP, ST_READY, ST_SLEEP,
    ST_ASLEEP, ST_WAKE_RST, ST_WAKE_PD, ST_ERROR
  } psr_state_e;

  // microseconds to clock cycles, rounded up
  function automatic int unsigned us_to_cyc(input longint unsigned hz,
                                            input longint unsigned us);
    longint unsigned c;
    c = (hz * us + 64'd999999) / 64'd1000000;
    return c[31:0];
  endfunction
endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= 2'b00;
      else        ff <= {ff[0], d[i]};
    end
    assign q[i] = ff[1];
  end
endmodule

// File: rtl/psr_req_latch.sv
module psr_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (req) pend <= 1'b1;   // a fresh request outranks a clear
    else if (clr) pend <= 1'b0;
  end
endmodule

// File: rtl/psr_quiet.sv
module psr_quiet #(
  parameter int unsigned SETTLE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic quiet
);
  localparam int unsigned W = $clog2(SETTLE_CYC + 1);
  localparam logic [W-1:0] LOAD = W'(SETTLE_CYC);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= LOAD;
    else if (hold)        cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign quiet = hold || (cnt != '0);
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import psr_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 125_000_000,
  parameter int unsigned RST_PULSE_US = 10,
  parameter int unsigned SETTLE_US    = 20,
  parameter int unsigned HPD_LIMIT_US = 90_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supplies_ok,
  input  logic hpd_in,
  input  logic video_active,
  input  logic sleep_req,
  input  logic wake_req,
  output logic pd_pull,
  output logic rst_pull,
  output logic bus_quiet,
  output logic ready,
  output logic asleep,
  output logic timeout
);
  localparam int unsigned RST_RAW    = us_to_cyc(64'(CLK_HZ), 64'(RST_PULSE_US));
  localparam int unsigned RST_CYC    = (RST_RAW < 2) ? 2 : RST_RAW;
  localparam int unsigned SETTLE_CYC = us_to_cyc(64'(CLK_HZ), 64'(SETTLE_US));
  localparam int unsigned HPD_RAW    = us_to_cyc(64'(CLK_HZ), 64'(HPD_LIMIT_US));
  localparam int unsigned HPD_CYC    = (HPD_RAW < 2) ? 2 : HPD_RAW;
  localparam int unsigned CNT_W      = $clog2(HPD_CYC + RST_CYC + 1);
  localparam logic [CNT_W-1:0] HPD_LAST = CNT_W'(HPD_CYC - 1);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYC - 1);

  logic [1:0] sync_q;
  logic       hpd_s, sup_s;

  psr_sync #(.WIDTH(2)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .d   ({hpd_in, supplies_ok}),
    .q   (sync_q)
  );
  assign hpd_s = sync_q[1];
  assign sup_s = sync_q[0];

  psr_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt;
  logic sleep_pend, wake_pend, sleep_clr, wake_clr;
  logic go_sleep, go_wake, err_pd, to_q;

  psr_req_latch u_sleep_pend (
    .clk (clk), .rst_n (rst_n), .req (sleep_req), .clr (sleep_clr), .pend (sleep_pend)
  );
  psr_req_latch u_wake_pend (
    .clk (clk), .rst_n (rst_n), .req (wake_req), .clr (wake_clr), .pend (wake_pend)
  );

  // request acceptance; wake outranks sleep in the error state
  always_comb begin
    go_wake  = !video_active && wake_pend &&
               (st_q == ST_ASLEEP || st_q == ST_ERROR);
    go_sleep = !video_active && sleep_pend &&
               (st_q == ST_READY || (st_q == ST_ERROR && !wake_pend));
    // a sleep request while asleep, or a lone wake while ready, is discarded
    sleep_clr = go_sleep || (st_q == ST_ASLEEP && sleep_pend);
    wake_clr  = go_wake  || (st_q == ST_READY && wake_pend && !sleep_pend);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_PWRUP:    if (sup_s) st_d = ST_WAIT_UP;
      ST_WAIT_UP:  if (hpd_s) st_d = ST_READY;
                   else if (cnt == HPD_LAST) st_d = ST_ERROR;
      ST_READY:    if (go_sleep) st_d = ST_SLEEP;
      ST_SLEEP:    if (!hpd_s) st_d = ST_ASLEEP;
                   else if (cnt == HPD_LAST) st_d = ST_ERROR;
      ST_ASLEEP:   if (go_wake) st_d = ST_WAKE_RST;
      ST_WAKE_RST: st_d = ST_WAKE_PD;
      ST_WAKE_PD:  if (cnt == RST_LAST) st_d = ST_WAIT_UP;
      ST_ERROR:    if (go_wake) st_d = ST_WAKE_RST;
                   else if (go_sleep) st_d = ST_SLEEP;
      default:     st_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PWRUP;
      cnt    <= '0;
      err_pd <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q)  cnt <= '0;
      else if (cnt != '1) cnt <= cnt + 1'b1;
      if (st_d == ST_ERROR && st_q != ST_ERROR) begin
        err_pd <= (st_q == ST_SLEEP);
        to_q   <= 1'b1;
      end else if (go_sleep || go_wake) begin
        to_q   <= 1'b0;
      end
    end
  end

  // open-drain: outputs are pull-low enables only
  assign rst_pull = (st_q == ST_PWRUP) || (st_q == ST_WAKE_RST) || (st_q == ST_WAKE_PD);
  assign pd_pull  = (st_q == ST_SLEEP) || (st_q == ST_ASLEEP) ||
                    (st_q == ST_WAKE_RST) || (st_q == ST_ERROR && err_pd);
  assign ready    = (st_q == ST_READY);
  assign asleep   = (st_q == ST_ASLEEP);
  assign timeout  = to_q;

  psr_quiet #(.SETTLE_CYC(SETTLE_CYC)) u_quiet (
    .clk (clk), .rst_n (rst_n), .hold (rst_pull), .quiet (bus_quiet)
  );
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk
  import psr_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 125_000_000,
  parameter int unsigned RST_PULSE_US = 10
) (
  input logic clk,
  input logic rst_n,
  input logic video_active,
  input logic pd_pull,
  input logic rst_pull,
  input logic bus_quiet,
  input logic ready,
  input logic asleep
);
  localparam int unsigned RST_RAW = us_to_cyc(64'(CLK_HZ), 64'(RST_PULSE_US));
  localparam int unsigned RST_CYC = (RST_RAW < 2) ? 2 : RST_RAW;

  logic        prev_rst, woke;
  int unsigned lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rst <= 1'b1;
      woke     <= 1'b0;
      lo_cnt   <= 0;
    end else begin
      prev_rst <= rst_pull;
      woke     <= woke | (rst_pull & ~prev_rst);
      lo_cnt   <= rst_pull ? lo_cnt + 1 : 0;
    end
  end

  AST_READY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!pd_pull && !rst_pull)) else $error("ready with pin pulled"); // R1
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready, asleep})) else $error("ready and asleep together"); // R1
  AST_PD_UNDER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_pull) |-> rst_pull) else $error("power-down released outside reset"); // R3
  AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_rst && !rst_pull && woke) |-> (lo_cnt >= RST_CYC)) else $error("reset pulse short"); // R4
  AST_ASLEEP_PD: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> pd_pull) else $error("asleep with power-down released"); // R6
  AST_QUIET_RST: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pull |-> bus_quiet) else $error("bus open during reset"); // R7
  AST_VIDEO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_pull) |-> !$past(video_active)) else $error("sleep during video"); // R8
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk #(
  .CLK_HZ(CLK_HZ), .RST_PULSE_US(RST_PULSE_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .video_active(video_active), .pd_pull(pd_pull),
  .rst_pull(rst_pull), .bus_quiet(bus_quiet), .ready(ready), .asleep(asleep)
);

// File: tb/pwrseq_ctrl_tb.sv
module pwrseq_ctrl_tb;
  localparam int unsigned HZ = 1_000_000;   // 1 cycle per microsecond
  localparam int RST_CYC = 10, SETTLE_CYC = 20, HPD_CYC = 300;

  logic clk = 0, rst_n = 0;
  logic supplies_ok = 0, hpd_in = 0, video_active = 0, sleep_req = 0, wake_req = 0;
  logic pd_pull, rst_pull, bus_quiet, ready, asleep, timeout;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;   // 125 MHz

  pwrseq_ctrl #(.CLK_HZ(HZ), .RST_PULSE_US(10), .SETTLE_US(20), .HPD_LIMIT_US(300)) u_dut (
    .clk(clk), .rst_n(rst_n), .supplies_ok(supplies_ok), .hpd_in(hpd_in),
    .video_active(video_active), .sleep_req(sleep_req), .wake_req(wake_req),
    .pd_pull(pd_pull), .rst_pull(rst_pull), .bus_quiet(bus_quiet),
    .ready(ready), .asleep(asleep), .timeout(timeout));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit asleep_exp(input bit pd, input bit hpd_low);
    return pd && hpd_low;   // asleep only once power-down is pulled and HPD is low
  endfunction

  // monitor for wake ordering, pulse width and asleep-before-wake
  logic pr_rst = 1, pr_pd = 0, seen_asleep = 0;
  int lo_w = 0;
  always @(negedge clk) if (rst_n) begin
    if (pr_pd && !pd_pull) chk(rst_pull, "R3 pd release under reset", rst_pull, 1);
    if (!pr_rst && rst_pull) chk(pd_pull, "R3 reset before pd release", pd_pull, 1);
    if (pr_rst && !rst_pull && lo_w < 100)
      chk(lo_w >= RST_CYC, "R4 reset pulse width", lo_w, RST_CYC);
    lo_w = rst_pull ? lo_w + 1 : 0;
    if (asleep) seen_asleep = 1;
    pr_rst = rst_pull; pr_pd = pd_pull;
  end

  task automatic pulse(ref logic s);
    s = 1; cyc(1); s = 0;
  endtask

  task automatic do_sleep(input int vhold, input int hdly);
    if (vhold > 0) video_active = 1;
    pulse(sleep_req);
    if (vhold > 0) begin
      cyc(vhold);
      chk(pd_pull == 0, "R8 sleep held by video", pd_pull, 0);
      video_active = 0;
    end
    cyc(hdly);
    chk(pd_pull == 1, "R6 pd pulled", pd_pull, 1);
    chk(asleep == asleep_exp(pd_pull, 0), "R6 asleep waits for HPD", asleep, 0);
    hpd_in = 0; cyc(5);
    chk(asleep == asleep_exp(pd_pull, 1), "R6 asleep after HPD fall", asleep, 1);
  endtask

  task automatic do_wake(input int hdly);
    pulse(wake_req);
    cyc(hdly);
    chk(ready == 0, "R5 not ready before HPD", ready, 0);
    hpd_in = 1; cyc(5);
    chk(ready == 1, "R5 ready after HPD", ready, 1);
    chk(timeout == 0, "R9 no timeout", timeout, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    chk(rst_pull == 1 && bus_quiet == 1 && pd_pull == 0, "R2 R7 reset state", {rst_pull, bus_quiet, pd_pull}, 3'b110);
    rst_n = 1; cyc(50);
    chk(rst_pull == 1, "R2 held until supplies", rst_pull, 1);
    chk(ready == 0, "R1 not ready", ready, 0);
    supplies_ok = 1; cyc(4);
    chk(rst_pull == 0, "R2 released after supplies", rst_pull, 0);
    begin
      int n = 0;
      while (bus_quiet && n < 100) begin cyc(1); n++; end
      // rst fell at the 3rd negedge, 1 cycle before measurement started
      chk(n == SETTLE_CYC - 1, "R7 settle length", n + 1, SETTLE_CYC);
    end
    cyc(40); hpd_in = 1; cyc(5);
    chk(ready == 1, "R5 ready after power-up", ready, 1);

    do_sleep(30, 40);
    do_wake(20);

    // sleep entry timeout: HPD never falls
    pulse(sleep_req); cyc(HPD_CYC - 20);
    chk(timeout == 0, "R6 no early timeout", timeout, 0);
    cyc(30);
    chk(timeout == 1 && asleep == 0, "R6 sleep timeout", {timeout, asleep}, 2'b10);
    cyc(20);
    chk(timeout == 1, "R9 timeout sticky", timeout, 1);
    pulse(wake_req); cyc(25);
    chk(timeout == 0 && ready == 1, "R9 wake from error", {timeout, ready}, 2'b01);

    // queued wake during sleep entry
    pulse(sleep_req); cyc(5);
    seen_asleep = 0;
    pulse(wake_req); cyc(10);
    chk(rst_pull == 0 && asleep == 0, "R10 wake queued", {rst_pull, asleep}, 0);
    hpd_in = 0; cyc(8);
    chk(seen_asleep && rst_pull, "R10 asleep then wake", {seen_asleep, rst_pull}, 2'b11);
    cyc(20); hpd_in = 1; cyc(5);
    chk(ready == 1, "R10 ready after queued wake", ready, 1);

    // wake timeout: HPD never rises
    do_sleep(0, 10);
    pulse(wake_req); cyc(HPD_CYC + 30);
    chk(timeout == 1 && ready == 0 && pd_pull == 0, "R5 wake timeout", {timeout, ready, pd_pull}, 3'b100);
    hpd_in = 1; pulse(sleep_req); cyc(10);
    chk(timeout == 0 && pd_pull == 1, "R9 sleep from error", {timeout, pd_pull}, 2'b01);
    hpd_in = 0; cyc(5);
    chk(asleep == 1, "R6 asleep from error path", asleep, 1);
    do_wake(20);

    for (int i = 0; i < 6; i++) begin
      do_sleep(($urandom % 2) ? int'($urandom % 20) + 1 : 0, int'($urandom % 100) + 5);
      do_wake(int'($urandom % 100) + 15);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule